// File: doc/BRIEF.md
# Channel Attenuator and Soft Mute

This block sits in the sample path of a stereo audio converter, ahead of the interpolation stage. Each valid left/right sample pair is scaled by an 8-bit linear gain per channel, capped by a soft-mute ceiling that ramps, routed through a 4-bit channel arrangement selector, and forced to zero when operation is disabled or when an enabled zero detector reports silence. The result appears one clock after the sample is accepted.

Gain codes come from control fields that are applied only while their own load bit is high. Until then the block keeps the code it applied last. A shared mode lets the left code govern both channels. The soft mute never steps the gain. Each accepted sample moves a ceiling by one code toward 0 (mute) or toward full scale (release), and each channel's effective gain is the lesser of its code and the ceiling.

Top module: `chan_gain_mute`

## Requirements
- R1: A channel's scaled value is sample × gain / 255, truncated toward zero. Gain FFh passes the sample unchanged and gain 00h yields zero.
- R2: A channel's applied gain code takes the value of its code input only at clock edges where that channel's load bit is high. Otherwise it keeps its last value. After reset both applied codes are FFh.
- R3: While shared mode is high, the right channel uses the left channel's applied code. While it is low, each channel uses its own applied code.
- R4: While mute is requested, the mute ceiling falls by one at each accepted sample until it reaches 0. It starts at FFh after reset.
- R5: While mute is not requested, the ceiling rises by one at each accepted sample until it reaches FFh. Each channel's effective gain is the lesser of its applied code and the ceiling.
- R6: When the disable input is high with a sample, both outputs for that sample are zero.
- R7: When zero detection is enabled and the zero flag is high with a sample, both outputs for that sample are zero. With detection disabled the zero flag has no effect.
- R8: Mode bits [3:2] pick the left output source and bits [1:0] pick the right output source. The source codes are 00 silence, 01 scaled right, 10 scaled left and 11 their average. So 1001 is stereo, 0110 is reverse stereo, 1111 is mono and 0000 is silence on both outputs.
- R9: The average is floor((L+R)/2), formed with one extra bit so that it cannot overflow at full-scale inputs of either sign.
- R10: Outputs update one clock after a valid sample and hold when no sample is valid. The output valid flag repeats the input valid one clock later. After reset both outputs are zero and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair is present |
| in_left | input | W | Left sample, two's complement |
| in_right | input | W | Right sample, two's complement |
| gain_code_l | input | 8 | Left gain code |
| gain_load_l | input | 1 | Apply left gain code |
| gain_code_r | input | 8 | Right gain code |
| gain_load_r | input | 1 | Apply right gain code |
| gain_shared | input | 1 | Left code drives both channels |
| mute_req | input | 1 | Ramp toward silence |
| op_disable | input | 1 | Force outputs to zero |
| zdet_enable | input | 1 | Allow the zero flag to force zero |
| zero_flag | input | 1 | Input has been zero for a long time |
| route_mode | input | 4 | Output channel arrangement |
| out_valid | output | 1 | Output pair is new |
| out_left | output | W | Left output |
| out_right | output | W | Right output |

## Verification
The hardest state to reach is the interaction between a partly ramped mute ceiling and a gain code below full scale. The effective gain then switches from the code to the ceiling partway through the ramp. That switch point is visible only after hundreds of accepted samples. The stimulus holds mute for more than 255 samples at a mid-range code, with valid gaps mixed in, then releases it for as long again. A reference model follows the ceiling sample by sample and compares both outputs on every clock.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] UNITY = '1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_AVG   = 2'b11
  } src_e;

  function automatic logic [CODE_W-1:0] lesser(input logic [CODE_W-1:0] a,
                                               input logic [CODE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/chg_gain_ctrl.sv
module chg_gain_ctrl
  import chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] code_l,
  input  logic              load_l,
  input  logic [CODE_W-1:0] code_r,
  input  logic              load_r,
  input  logic              shared,
  input  logic              mute_req,
  output logic [CODE_W-1:0] gain_l,
  output logic [CODE_W-1:0] gain_r
);
  logic [CODE_W-1:0] act_l_q, act_r_q, ceil_q;
  logic [CODE_W-1:0] code_r_used;
  logic              ceil_at_floor, ceil_at_top;

  assign ceil_at_floor = (ceil_q == '0);
  assign ceil_at_top   = (ceil_q == UNITY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_l_q <= UNITY;
      act_r_q <= UNITY;
      ceil_q  <= UNITY;
    end else begin
      if (load_l) act_l_q <= code_l;
      if (load_r) act_r_q <= code_r;
      if (smp_valid) begin
        if (mute_req) begin
          if (!ceil_at_floor) ceil_q <= ceil_q - 1'b1;
        end else if (!ceil_at_top) begin
          ceil_q <= ceil_q + 1'b1;
        end
      end
    end
  end

  assign code_r_used = shared ? act_l_q : act_r_q;
  assign gain_l      = lesser(act_l_q, ceil_q);
  assign gain_r      = lesser(code_r_used, ceil_q);

  // R2: an applied code moves only under its load bit
  a_r2_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    !load_l |=> $stable(act_l_q));
  a_r2_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    !load_r |=> $stable(act_r_q));
  // R4: the ceiling moves by at most one code per accepted sample
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (ceil_q == $past(ceil_q)) || (ceil_q == $past(ceil_q) + 8'd1)
                  || (ceil_q + 8'd1 == $past(ceil_q)));
  a_r4_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(ceil_q));
  // R5: the effective gain never exceeds the ceiling
  a_r5_gain_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l <= ceil_q) && (gain_r <= ceil_q));
endmodule

// File: rtl/chg_scale.sv
module chg_scale
  import chg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic signed [W-1:0]      sample,
  input  logic        [CODE_W-1:0] gain,
  output logic signed [W-1:0]      scaled
);
  localparam int PW = W + CODE_W + 1;
  localparam logic signed [PW-1:0] DIVISOR = PW'(255);

  function automatic logic signed [W-1:0] atten_mul(input logic signed [W-1:0] s,
                                                    input logic [CODE_W-1:0] g);
    logic signed [PW-1:0] prod, quot;
    prod = PW'(s) * $signed({1'b0, g});
    quot = prod / DIVISOR;
    return quot[W-1:0];
  endfunction

  assign scaled = atten_mul(sample, gain);

  // R1: full-scale gain is transparent, zero gain silences
  always_comb begin
    if (gain == UNITY) a_r1_unity: assert (scaled == sample);
    if (gain == '0)    a_r1_silent: assert (scaled == '0);
  end
endmodule

// File: rtl/chg_router.sv
module chg_router
  import chg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic signed [W-1:0] chan_l,
  input  logic signed [W-1:0] chan_r,
  input  logic        [3:0]   mode,
  output logic signed [W-1:0] mix_l,
  output logic signed [W-1:0] mix_r,
  output logic signed [W-1:0] avg_o
);
  logic signed [W:0] sum_wide;

  function automatic logic signed [W-1:0] pick(input src_e src,
                                               input logic signed [W-1:0] l,
                                               input logic signed [W-1:0] r,
                                               input logic signed [W-1:0] a);
    case (src)
      SRC_RIGHT: return r;
      SRC_LEFT:  return l;
      SRC_AVG:   return a;
      default:   return '0;
    endcase
  endfunction

  assign sum_wide = {chan_l[W-1], chan_l} + {chan_r[W-1], chan_r};
  assign avg_o    = sum_wide[W:1];
  assign mix_l    = pick(src_e'(mode[3:2]), chan_l, chan_r, avg_o);
  assign mix_r    = pick(src_e'(mode[1:0]), chan_l, chan_r, avg_o);

  // R9: the average lies between its two operands
  always_comb begin
    a_r9_no_overflow: assert (((avg_o >= chan_l) && (avg_o <= chan_r)) ||
                              ((avg_o >= chan_r) && (avg_o <= chan_l)));
  end
endmodule

// File: rtl/chan_gain_mute.sv
module chan_gain_mute
  import chg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_left,
  input  logic signed [W-1:0]  in_right,
  input  logic [7:0]           gain_code_l,
  input  logic                 gain_load_l,
  input  logic [7:0]           gain_code_r,
  input  logic                 gain_load_r,
  input  logic                 gain_shared,
  input  logic                 mute_req,
  input  logic                 op_disable,
  input  logic                 zdet_enable,
  input  logic                 zero_flag,
  input  logic [3:0]           route_mode,
  output logic                 out_valid,
  output logic signed [W-1:0]  out_left,
  output logic signed [W-1:0]  out_right
);
  localparam int NCH = 2;

  logic [CODE_W-1:0]  gain [NCH];
  logic signed [W-1:0] smp  [NCH];
  logic signed [W-1:0] scl  [NCH];
  logic signed [W-1:0] mix_l, mix_r, avg_w;
  logic                force_zero;
  logic                vld_q;
  logic signed [W-1:0] out_l_q, out_r_q;

  assign smp[0] = in_left;
  assign smp[1] = in_right;

  chg_gain_ctrl u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (in_valid),
    .code_l    (gain_code_l),
    .load_l    (gain_load_l),
    .code_r    (gain_code_r),
    .load_r    (gain_load_r),
    .shared    (gain_shared),
    .mute_req  (mute_req),
    .gain_l    (gain[0]),
    .gain_r    (gain[1])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chg_scale #(.W(W)) u_scale (
      .sample (smp[c]),
      .gain   (gain[c]),
      .scaled (scl[c])
    );
  end

  chg_router #(.W(W)) u_route (
    .chan_l (scl[0]),
    .chan_r (scl[1]),
    .mode   (route_mode),
    .mix_l  (mix_l),
    .mix_r  (mix_r),
    .avg_o  (avg_w)
  );

  assign force_zero = op_disable | (zdet_enable & zero_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      out_l_q <= '0;
      out_r_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        out_l_q <= force_zero ? '0 : mix_l;
        out_r_q <= force_zero ? '0 : mix_r;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_left  = out_l_q;
  assign out_right = out_r_q;

  // R6: disable silences the next output pair
  a_r6_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_disable |=> (out_left == '0) && (out_right == '0));
  // R7: an enabled zero flag silences the next output pair
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zdet_enable && zero_flag |=> (out_left == '0) && (out_right == '0));
  // R3: shared gain with equal inputs in stereo gives equal outputs
  a_r3_shared_equal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gain_shared && (in_left == in_right) && (route_mode == 4'b1001)
    |=> out_left == out_right);
  // R10: outputs hold without a valid sample
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_left) && $stable(out_right) && !out_valid);
endmodule

// File: tb/test_chan_gain_mute.sv
module test_chan_gain_mute;
  localparam int W = 24;
  localparam longint SMAX = (longint'(1) <<< (W-1)) - 1;
  localparam longint SMIN = -(longint'(1) <<< (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_left = '0, in_right = '0;
  logic [7:0] gain_code_l = 8'hFF, gain_code_r = 8'hFF;
  logic gain_load_l = 1'b0, gain_load_r = 1'b0, gain_shared = 1'b0;
  logic mute_req = 1'b0, op_disable = 1'b0, zdet_enable = 1'b0, zero_flag = 1'b0;
  logic [3:0] route_mode = 4'b1001;
  logic out_valid;
  logic signed [W-1:0] out_left, out_right;

  int tests = 0, fails = 0;
  string tag = "R10";
  bit done = 0;
  int cyc = 0;

  // reference state
  int act_l = 255, act_r = 255, ceil_v = 255;
  longint exp_l = 0, exp_r = 0;
  bit exp_v = 0;

  always #4 clk = ~clk;

  chan_gain_mute #(.W(W)) i_chan_gain_mute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .gain_code_l(gain_code_l), .gain_load_l(gain_load_l), .gain_code_r(gain_code_r),
    .gain_load_r(gain_load_r), .gain_shared(gain_shared), .mute_req(mute_req),
    .op_disable(op_disable), .zdet_enable(zdet_enable), .zero_flag(zero_flag),
    .route_mode(route_mode), .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  function automatic longint src_val(int sel, longint l, longint r);
    case (sel)
      1: return r;
      2: return l;
      3: return (l + r) >>> 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      act_l = 255; act_r = 255; ceil_v = 255;
      exp_l = 0; exp_r = 0; exp_v = 0;
    end else begin
      int gl, gr, rc;
      longint sl, sr;
      gl = (act_l < ceil_v) ? act_l : ceil_v;
      rc = gain_shared ? act_l : act_r;
      gr = (rc < ceil_v) ? rc : ceil_v;
      sl = (longint'(in_left) * gl) / 255;
      sr = (longint'(in_right) * gr) / 255;
      exp_v = in_valid;
      if (in_valid) begin
        if (op_disable || (zdet_enable && zero_flag)) begin
          exp_l = 0; exp_r = 0;
        end else begin
          exp_l = src_val(int'(route_mode[3:2]), sl, sr);
          exp_r = src_val(int'(route_mode[1:0]), sl, sr);
        end
        if (mute_req) begin if (ceil_v > 0) ceil_v--; end
        else if (ceil_v < 255) ceil_v++;
      end
      if (gain_load_l) act_l = int'(gain_code_l);
      if (gain_load_r) act_r = int'(gain_code_r);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n || tag == "R10") begin
      tests++;
      if (out_valid !== exp_v || longint'(out_left) != exp_l || longint'(out_right) != exp_r) begin
        fails++;
        $display("FAIL %s: act v=%0b l=%0d r=%0d exp v=%0b l=%0d r=%0d",
                 tag, out_valid, out_left, out_right, exp_v, exp_l, exp_r);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: act running exp finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(int n, int valid_pct, bit extreme);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = ($urandom_range(99) < valid_pct);
      if (extreme) begin
        in_left  = $urandom_range(1) ? W'(SMAX) : W'(SMIN);
        in_right = $urandom_range(1) ? W'(SMAX) : W'(SMIN);
      end else begin
        in_left  = W'($urandom);
        in_right = W'($urandom);
      end
    end
  endtask

  task automatic load_codes(logic [7:0] cl, logic [7:0] cr);
    @(negedge clk);
    gain_code_l = cl; gain_code_r = cr;
    gain_load_l = 1; gain_load_r = 1;
    @(negedge clk);
    gain_load_l = 0; gain_load_r = 0;
  endtask

  initial begin
    // R10: reset state
    tag = "R10";
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    run(20, 100, 0);
    load_codes(8'h00, 8'h80);
    run(20, 100, 1);
    load_codes(8'h01, 8'hFE);
    run(20, 100, 1);
    // R2: new codes written but not loaded
    tag = "R2";
    @(negedge clk); gain_code_l = 8'h40; gain_code_r = 8'h10;
    run(15, 100, 0);
    @(negedge clk); gain_load_l = 1;
    run(10, 100, 0);
    gain_load_l = 0; gain_load_r = 1;
    run(5, 100, 0);
    gain_load_r = 0;
    // R3: shared code
    tag = "R3";
    load_codes(8'hC0, 8'h20);
    gain_shared = 1;
    run(20, 100, 0);
    gain_shared = 0;
    run(10, 100, 0);
    // R4/R5: ramp with mid code and gaps
    tag = "R4";
    load_codes(8'h80, 8'hFF);
    mute_req = 1;
    run(400, 80, 0);
    tag = "R5";
    mute_req = 0;
    run(400, 80, 0);
    // R6: disable forcing
    tag = "R6";
    op_disable = 1;
    run(20, 100, 1);
    op_disable = 0;
    // R7: zero flag with detection off then on
    tag = "R7";
    zero_flag = 1;
    run(15, 100, 0);
    zdet_enable = 1;
    run(15, 100, 0);
    zero_flag = 0;
    run(10, 100, 0);
    zdet_enable = 0;
    // R8: every arrangement
    tag = "R8";
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); route_mode = 4'(m);
      run(8, 100, 0);
    end
    // R9: full-scale average
    tag = "R9";
    load_codes(8'hFF, 8'hFF);
    route_mode = 4'b1111;
    run(40, 100, 1);
    // R10: sparse valid
    tag = "R10";
    route_mode = 4'b1001;
    run(60, 40, 0);
    @(negedge clk); in_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule